// File: doc/BRIEF.md
# Counting Semaphore Cell

A single shared semaphore cell that several threads use to synchronise through a small set of access views. Each cycle every request port may carry one access. A read on a semaphore view takes a unit (the P operation) and a write gives one back (the V operation). Either operation exists in a waiting form and a polling form. The cell holds a 16-bit count and a mask with one bit per thread recording which threads are parked on it.

A waiting take that finds the count at zero leaves the count alone. It records the caller in the waiter mask and answers with a block response. The next give pulses a wake vector naming every parked thread and empties the mask. A woken thread is not served automatically: it must issue its take again. A raw view exposes the count directly, and a configuration view holds a single queue-mode flag. While that flag is set, the semaphore views do nothing. Read data, block and wake are all registered and appear one cycle after the request.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the queue-mode flag is 0, the waiter mask is empty, and rd_data_o, blocked_o and wake_o are all 0.
- R2: A read (req_write_i=0) on view 2 or view 3 returns on rd_data_o, one cycle later, the count held just before that port's take. It decrements the count when the count is above zero. Writes and idle ports return 0 on rd_data_o.
- R3: A view-2 read of a zero count raises blocked_o for that port one cycle later and returns 0. It sets bit req_tid_i of the waiter mask. A view-3 read of a zero count returns 0, does not block and changes no state.
- R4: A write (req_write_i=1) on view 2 or view 3 increments the count and ignores req_wdata_i. When the count is 0xFFFF it stays at 0xFFFF.
- R5: A give that finds the waiter mask non-empty drives wake_o with that mask for exactly one cycle, one cycle later, and empties the mask. Threads that block in the same cycle stay registered.
- R6: While the queue-mode flag is 1, reads on views 2 and 3 return 0 and never block. Writes on those views change nothing and wake nobody.
- R7: A view-0 read returns the count held at the start of the cycle. A view-0 write is ignored.
- R8: A view-1 read returns the queue-mode flag in bit 0. A view-1 write loads the flag from req_wdata_i and leaves the count unchanged. When several ports write it in one cycle, the highest port index wins. The new flag takes effect from the next cycle.
- R9: Within one cycle all gives are applied before any take, and takes are served in ascending port order. A waiting take paired with a give on a zero count therefore proceeds without blocking.
- R10: A wake does not perform a take on the woken thread's behalf. The count changes only through explicit requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NPORT | Request present, one bit per port |
| req_write_i | input | NPORT | 1 = write, 0 = read, per port |
| req_view_i | input | NPORT x 2 | View: 0 raw, 1 config, 2 waiting P/V, 3 polling P/V |
| req_tid_i | input | NPORT x TID_W | Requesting thread id |
| req_wdata_i | input | NPORT | Write data bit (used by the config view only) |
| rd_data_o | output | NPORT x CNT_W | Registered read result |
| blocked_o | output | NPORT | Registered block response |
| wake_o | output | NTHREAD | Registered one-cycle wake vector |

## Verification
Several properties are checked on every cycle. A block response appears only with a zero count and a non-empty mask. Woken threads are always a subset of the previous mask. The count never wraps in either direction. Queue mode freezes the count and suppresses block and wake. The exact return values, port ordering within a cycle, the same-cycle give/take pairing, saturation at 0xFFFF, config-port priority and the reissue after wake can only be shown by the bench's directed scenarios and its reference model under random traffic.

// File: rtl/semcell_pkg.sv
package semcell_pkg;
  typedef enum logic [1:0] {
    VW_RAW  = 2'd0,
    VW_CFG  = 2'd1,
    VW_WAIT = 2'd2,
    VW_POLL = 2'd3
  } view_e;
endpackage

// File: rtl/semcell_give.sv
module semcell_give #(
  parameter int NPORT = 2,
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [NPORT-1:0] give_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             any_o
);
  localparam int PC_W  = $clog2(NPORT + 1);
  localparam int SUM_W = CNT_W + PC_W;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'({CNT_W{1'b1}});

  logic [PC_W-1:0]  n_give;
  logic [SUM_W-1:0] sum;

  always_comb begin
    n_give = '0;
    for (int i = 0; i < NPORT; i++) n_give = n_give + PC_W'(give_i[i]);
    sum   = SUM_W'(cnt_i) + SUM_W'(n_give);
    cnt_o = (sum > LIMIT) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  assign any_o = |give_i;
endmodule

// File: rtl/semcell_take.sv
module semcell_take #(
  parameter int NPORT = 2,
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [NPORT-1:0]            take_i,
  input  logic [NPORT-1:0]            wait_i,
  output logic [CNT_W-1:0]            cnt_o,
  output logic [NPORT-1:0][CNT_W-1:0] val_o,
  output logic [NPORT-1:0]            blk_o
);
  logic [CNT_W-1:0] stage [NPORT+1];

  assign stage[0] = cnt_i;

  // takes served in ascending port order
  for (genvar p = 0; p < NPORT; p++) begin : g_stage
    logic nz;
    assign nz           = |stage[p];
    assign val_o[p]     = take_i[p] ? stage[p] : '0;
    assign blk_o[p]     = take_i[p] && wait_i[p] && !nz;
    assign stage[p+1]   = (take_i[p] && nz) ? stage[p] - CNT_W'(1) : stage[p];
  end

  assign cnt_o = stage[NPORT];
endmodule

// File: rtl/semcell_waiters.sv
module semcell_waiters #(
  parameter int NPORT   = 2,
  parameter int NTHREAD = 8,
  parameter int TID_W   = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NPORT-1:0]            blk_i,
  input  logic [NPORT-1:0][TID_W-1:0] tid_i,
  input  logic                        give_i,
  output logic [NTHREAD-1:0]          mask_o,
  output logic [NTHREAD-1:0]          wake_o
);
  logic [NTHREAD-1:0] mask_q, mask_d, add, wake_q;

  always_comb begin
    add = '0;
    for (int p = 0; p < NPORT; p++)
      if (blk_i[p]) add[tid_i[p]] = 1'b1;
    // give empties the old mask; same-cycle blockers remain
    mask_d = (give_i ? '0 : mask_q) | add;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      wake_q <= '0;
    end else begin
      mask_q <= mask_d;
      wake_q <= give_i ? mask_q : '0;
    end
  end

  assign mask_o = mask_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import semcell_pkg::*;
#(
  parameter int NPORT   = 2,
  parameter int NTHREAD = 8,
  parameter int CNT_W   = 16,
  parameter int TID_W   = (NTHREAD > 1) ? $clog2(NTHREAD) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NPORT-1:0]            req_valid_i,
  input  logic [NPORT-1:0]            req_write_i,
  input  logic [NPORT-1:0][1:0]       req_view_i,
  input  logic [NPORT-1:0][TID_W-1:0] req_tid_i,
  input  logic [NPORT-1:0]            req_wdata_i,
  output logic [NPORT-1:0][CNT_W-1:0] rd_data_o,
  output logic [NPORT-1:0]            blocked_o,
  output logic [NTHREAD-1:0]          wake_o
);
  logic [CNT_W-1:0]            cnt_q, cnt_given, cnt_d;
  logic                        fifo_q, fifo_d;
  logic [NPORT-1:0]            give, take, wait_mode, take_blk;
  logic                        any_give;
  logic [NPORT-1:0][CNT_W-1:0] take_val, rd_next, rd_q;
  logic [NPORT-1:0]            blk_q;
  logic [NTHREAD-1:0]          waiter_mask;

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    logic pv_hit;
    assign pv_hit       = req_valid_i[p] && !fifo_q &&
                          (req_view_i[p] == VW_WAIT || req_view_i[p] == VW_POLL);
    assign give[p]      = pv_hit && req_write_i[p];
    assign take[p]      = pv_hit && !req_write_i[p];
    assign wait_mode[p] = (req_view_i[p] == VW_WAIT);

    always_comb begin
      rd_next[p] = '0;
      if (req_valid_i[p] && !req_write_i[p]) begin
        case (req_view_i[p])
          VW_RAW:  rd_next[p] = cnt_q;
          VW_CFG:  rd_next[p] = CNT_W'(fifo_q);
          default: rd_next[p] = take_val[p];
        endcase
      end
    end
  end

  semcell_give #(.NPORT(NPORT), .CNT_W(CNT_W)) u_give (
    .cnt_i  (cnt_q),
    .give_i (give),
    .cnt_o  (cnt_given),
    .any_o  (any_give)
  );

  semcell_take #(.NPORT(NPORT), .CNT_W(CNT_W)) u_take (
    .cnt_i  (cnt_given),
    .take_i (take),
    .wait_i (wait_mode),
    .cnt_o  (cnt_d),
    .val_o  (take_val),
    .blk_o  (take_blk)
  );

  semcell_waiters #(.NPORT(NPORT), .NTHREAD(NTHREAD), .TID_W(TID_W)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .blk_i  (take_blk),
    .tid_i  (req_tid_i),
    .give_i (any_give),
    .mask_o (waiter_mask),
    .wake_o (wake_o)
  );

  // highest port index wins the config write
  always_comb begin
    fifo_d = fifo_q;
    for (int p = 0; p < NPORT; p++)
      if (req_valid_i[p] && req_write_i[p] && req_view_i[p] == VW_CFG)
        fifo_d = req_wdata_i[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fifo_q <= 1'b0;
      rd_q   <= '0;
      blk_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      fifo_q <= fifo_d;
      rd_q   <= rd_next;
      blk_q  <= take_blk;
    end
  end

  assign rd_data_o = rd_q;
  assign blocked_o = blk_q;
endmodule

// File: rtl/semcell_chk.sv
module semcell_chk #(
  parameter int NPORT   = 2,
  parameter int NTHREAD = 8,
  parameter int CNT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NPORT-1:0]   req_valid_i,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               fifo_q,
  input logic [NTHREAD-1:0] mask_q,
  input logic [NPORT-1:0]   blocked_o,
  input logic [NTHREAD-1:0] wake_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_valid_i) |=> ($stable(cnt_q) && $stable(fifo_q)));

  a_r2_no_wrap_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |=> (cnt_q != CMAX));

  a_r3_block_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|blocked_o) |-> (cnt_q == '0));

  a_r3_block_registers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|blocked_o) |-> (|mask_q));

  a_r4_no_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CMAX) |=> (cnt_q != '0));

  a_r5_wake_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o & ~$past(mask_q)) == '0);

  a_r6_fifo_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_q |=> ($stable(cnt_q) && !(|blocked_o) && (wake_o == '0)));
endmodule

bind sem_cell semcell_chk #(.NPORT(NPORT), .NTHREAD(NTHREAD), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .cnt_q       (cnt_q),
  .fifo_q      (fifo_q),
  .mask_q      (waiter_mask),
  .blocked_o   (blocked_o),
  .wake_o      (wake_o)
);

// File: tb/sim_sem_cell.sv
module sim_sem_cell;
  localparam int NPORT = 2, NTHREAD = 8, CNT_W = 16, TID_W = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NPORT-1:0]            req_valid = '0, req_write = '0, req_wdata = '0;
  logic [NPORT-1:0][1:0]       req_view = '0;
  logic [NPORT-1:0][TID_W-1:0] req_tid = '0;
  logic [NPORT-1:0][CNT_W-1:0] rd_data;
  logic [NPORT-1:0]            blocked;
  logic [NTHREAD-1:0]          wake;

  always #10 clk = ~clk;

  sem_cell #(.NPORT(NPORT), .NTHREAD(NTHREAD), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_view_i(req_view), .req_tid_i(req_tid), .req_wdata_i(req_wdata),
    .rd_data_o(rd_data), .blocked_o(blocked), .wake_o(wake));

  int checks = 0, fails = 0;
  string tag = "R1";
  int unsigned m_cnt;
  bit m_fifo;
  bit [NTHREAD-1:0] m_mask, e_wake;
  bit [CNT_W-1:0] e_rd [NPORT];
  bit e_blk [NPORT];

  function automatic void chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  function automatic void model_reset();
    m_cnt = 0; m_fifo = 0; m_mask = '0; e_wake = '0;
    for (int p = 0; p < NPORT; p++) begin e_rd[p] = '0; e_blk[p] = 0; end
  endfunction

  // expected outputs from the requirements: gives first, then takes by port
  function automatic void model_step();
    int unsigned start = m_cnt, cnt, nv = 0;
    bit fifo0 = m_fifo;
    e_wake = '0;
    for (int p = 0; p < NPORT; p++)
      if (req_valid[p] && req_write[p] && req_view[p] >= 2 && !fifo0) nv++;
    cnt = (m_cnt + nv > 65535) ? 65535 : m_cnt + nv;
    if (nv > 0) begin e_wake = m_mask; m_mask = '0; end
    for (int p = 0; p < NPORT; p++) begin
      e_rd[p] = '0; e_blk[p] = 0;
      if (req_valid[p] && !req_write[p]) begin
        case (req_view[p])
          2'd0: e_rd[p] = CNT_W'(start);
          2'd1: e_rd[p] = CNT_W'(fifo0);
          default: if (!fifo0) begin
            if (cnt > 0) begin e_rd[p] = CNT_W'(cnt); cnt--; end
            else if (req_view[p] == 2'd2) begin e_blk[p] = 1; m_mask[req_tid[p]] = 1'b1; end
          end
        endcase
      end
    end
    for (int p = 0; p < NPORT; p++)
      if (req_valid[p] && req_write[p] && req_view[p] == 2'd1) m_fifo = req_wdata[p];
    m_cnt = cnt;
  endfunction

  task automatic step();
    model_step();
    @(negedge clk);
    for (int p = 0; p < NPORT; p++) begin
      chk(tag, $sformatf("rd_data[%0d]", p), 32'(rd_data[p]), 32'(e_rd[p]));
      chk(tag, $sformatf("blocked[%0d]", p), 32'(blocked[p]), 32'(e_blk[p]));
    end
    chk(tag, "wake", 32'(wake), 32'(e_wake));
    req_valid = '0;
  endtask

  task automatic put(int p, bit wr, logic [1:0] view, int tid, bit wd);
    req_valid[p] = 1'b1; req_write[p] = wr; req_view[p] = view;
    req_tid[p] = TID_W'(tid); req_wdata[p] = wd;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req_valid = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
  endtask

  initial begin
    #(20ns * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    do_reset();
    // R1: reset state, raw and config views read zero
    tag = "R1";
    for (int p = 0; p < NPORT; p++) begin
      chk("R1", "rd_data after reset", 32'(rd_data[p]), 0);
      chk("R1", "blocked after reset", 32'(blocked[p]), 0);
    end
    chk("R1", "wake after reset", 32'(wake), 0);
    put(0, 0, 2'd0, 0, 0); put(1, 0, 2'd1, 1, 0); step();

    // R4: gives ignore data; R2: takes return pre-decrement count
    tag = "R4";
    put(0, 1, 2'd3, 0, 1); step();
    put(1, 1, 2'd2, 1, 0); step();
    put(0, 1, 2'd3, 2, 1); step();
    tag = "R2";
    put(0, 0, 2'd3, 0, 0); step();
    put(1, 0, 2'd2, 1, 0); step();
    put(0, 0, 2'd3, 2, 0); step();
    put(1, 1, 2'd0, 3, 1); step();  // idle-equivalent write returns 0

    // R3: poll on zero is harmless, wait on zero blocks
    tag = "R3";
    put(0, 0, 2'd3, 4, 0); step();
    put(0, 0, 2'd2, 5, 0); step();
    put(1, 0, 2'd0, 0, 0); step();

    // R5 and R10: give wakes thread 5, which reissues
    tag = "R5";
    put(1, 1, 2'd3, 2, 0); step();
    put(1, 0, 2'd0, 0, 0); step();  // R10: count still 1 after wake
    tag = "R10";
    put(0, 0, 2'd2, 5, 0); step();

    // R9: two waiters, then same-cycle give and take on zero
    tag = "R9";
    put(0, 0, 2'd2, 1, 0); put(1, 0, 2'd2, 2, 0); step();
    put(0, 0, 2'd2, 3, 0); put(1, 1, 2'd2, 4, 0); step();
    put(1, 1, 2'd3, 4, 0); step();
    put(0, 0, 2'd2, 6, 0); put(1, 0, 2'd2, 7, 0); step();
    put(0, 1, 2'd2, 0, 0); step();

    // R7: raw write ignored
    tag = "R7";
    put(0, 1, 2'd0, 0, 1); step();
    put(1, 0, 2'd0, 0, 0); step();

    // R8 and R6: config priority and queue mode
    tag = "R8";
    put(0, 1, 2'd1, 0, 0); put(1, 1, 2'd1, 0, 1); step();
    put(0, 0, 2'd1, 0, 0); step();
    tag = "R6";
    put(0, 0, 2'd2, 2, 0); put(1, 1, 2'd3, 3, 0); step();
    put(0, 1, 2'd2, 2, 0); put(1, 0, 2'd3, 3, 0); step();
    put(0, 0, 2'd0, 0, 0); step();
    tag = "R8";
    put(0, 1, 2'd1, 0, 1); put(1, 1, 2'd1, 0, 0); step();
    put(1, 0, 2'd1, 0, 0); step();

    // R4: saturation at 0xFFFF
    tag = "R4";
    do_reset();
    for (int i = 0; i < 32768; i++) begin
      put(0, 1, 2'd3, 0, 0); put(1, 1, 2'd2, 1, 1); step();
    end
    put(0, 0, 2'd0, 0, 0); step();
    put(0, 1, 2'd2, 0, 0); step();
    put(0, 0, 2'd3, 0, 0); put(1, 0, 2'd3, 0, 0); step();

    // random traffic against the model
    tag = "R2,R3,R5,R6,R9";
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      for (int p = 0; p < NPORT; p++) begin
        int r = int'($urandom % 32);
        if ($urandom % 4 != 0) begin
          if (r == 0) put(p, 1, 2'd1, 0, ($urandom % 3) == 0);
          else if (r < 4) put(p, $urandom % 2, 2'd0, 0, $urandom % 2);
          else put(p, $urandom % 2, (r % 2) ? 2'd2 : 2'd3, int'($urandom % NTHREAD), $urandom % 2);
        end
      end
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule